// File: doc/BRIEF.md
# Gated Bit-Slice Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit with a configurable width. It is built as a chain of identical one-bit cells. Every cell computes four results at the same time: a full-adder sum, the inverse of operand A, the inclusive OR and the conjunction of its two operand bits.

A shared 2-to-4 decoder turns the two-bit function selector into a one-hot set of enables. Inside each cell, every unit output is ANDed with its enable, and the gated terms are ORed onto the cell's single result bit. No multiplexer or case statement picks the result.

The cells are linked only through the ripple carry. The external carry input enters the least significant cell, and all cells receive the same enables. A signed-overflow flag is taken from the carries around the top cell. The carry output and the overflow flag report only on addition.

Top module: `bitslice_alu`

## Requirements
- R1: With selector 2'b00, `result` equals (op_a + op_b + carry_in) modulo 2^WIDTH, and `carry_out` equals bit WIDTH of that full sum.
- R2: With selector 2'b01, `result` equals the bitwise inverse of op_a, whatever op_b is.
- R3: With selector 2'b10, `result` equals op_a OR op_b, bit by bit.
- R4: With selector 2'b11, `result` equals op_a AND op_b, bit by bit.
- R5: With selector 2'b00, `overflow_o` is 1 exactly when op_a and op_b have the same sign bit and the sign bit of `result` differs from it. This equals the carry into the top cell XOR the carry out of it.
- R6: With any selector other than 2'b00, `carry_out` and `overflow_o` are 0, and `carry_in` has no effect on `result`.
- R7: The decoder raises exactly one enable for each selector value, so `result` is fully driven and contains no unknown bit whenever the inputs are known.
- R8: The width is the parameter WIDTH (default 8). The cells are produced by a generate loop, and an instance with any width of 2 or more obeys R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| fn_sel | input | 2 | Operation selector (00 add, 01 invert A, 10 OR, 11 AND) |
| carry_in | input | 1 | Carry into the least significant cell |
| result | output | WIDTH | Gated result of the selected operation |
| carry_out | output | 1 | Carry from the top cell, addition only |
| overflow_o | output | 1 | Two's-complement overflow, addition only |

## Verification
The embedded checks are immediate and combinational. They assume that every input is a known 0 or 1 and has settled before it is examined, so each check is skipped while any input is unknown.

The bench changes its inputs only on one clock edge and reads the outputs half a period later, so the checks only ever see a settled carry chain. A 4-bit instance is swept over every operand pair, selector and carry value. An 8-bit instance takes the addition corner cases with both carry values, plus random operands for all four selectors.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_INV  = 2'b01,
    ALU_IOR  = 2'b10,
    ALU_CONJ = 2'b11
  } alu_fn_e;

  localparam int unsigned FN_COUNT = 4;
  localparam int unsigned FN_BITS  = $clog2(FN_COUNT);

endpackage

// File: rtl/alu_fn_decoder.sv
module alu_fn_decoder
  import alu_slice_pkg::*;
(
  input  logic [FN_BITS-1:0]  fn_code,
  output logic [FN_COUNT-1:0] fn_en
);

  for (genvar k = 0; k < FN_COUNT; k++) begin : g_line
    assign fn_en[k] = (fn_code == FN_BITS'(k));
  end

  // R7: a known selector must light exactly one line
  always_comb begin
    if (!$isunknown(fn_code)) begin
      p_one_enable_r7: assert ($countones(fn_en) == 1);
    end
  end

endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);

  logic prop;

  assign prop  = a_bit ^ b_bit;
  assign s_bit = prop ^ c_in;
  assign c_out = (a_bit & b_bit) | (c_in & prop);

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_slice_pkg::*;
(
  input  logic                a_bit,
  input  logic                b_bit,
  input  logic                c_in,
  input  logic [FN_COUNT-1:0] fn_en,
  output logic                r_bit,
  output logic                c_out
);

  logic u_add;
  logic u_inv;
  logic u_ior;
  logic u_conj;

  alu_full_adder fa_i (
    .a_bit (a_bit),
    .b_bit (b_bit),
    .c_in  (c_in),
    .s_bit (u_add),
    .c_out (c_out)
  );

  assign u_inv  = ~a_bit;
  assign u_ior  = a_bit | b_bit;
  assign u_conj = a_bit & b_bit;

  assign r_bit = (u_add  & fn_en[ALU_ADD])
               | (u_inv  & fn_en[ALU_INV])
               | (u_ior  & fn_en[ALU_IOR])
               | (u_conj & fn_en[ALU_CONJ]);

  always_comb begin
    if (!$isunknown({a_bit, b_bit, c_in, fn_en})) begin
      // R1: the adder carry is the majority of its three inputs
      p_carry_major_r1: assert (c_out == ((a_bit & b_bit) | (a_bit & c_in) | (b_bit & c_in)));
      if (fn_en[ALU_INV])  p_slice_inv_r2:  assert (r_bit != a_bit);
      if (fn_en[ALU_IOR])  p_slice_ior_r3:  assert (r_bit == (a_bit || b_bit));
      if (fn_en[ALU_CONJ]) p_slice_conj_r4: assert (r_bit == (a_bit && b_bit));
    end
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       fn_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [FN_COUNT-1:0] fn_en;
  logic [WIDTH:0]      chain;

  alu_fn_decoder dec_i (
    .fn_code (fn_sel),
    .fn_en   (fn_en)
  );

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice slice_i (
      .a_bit (op_a[i]),
      .b_bit (op_b[i]),
      .c_in  (chain[i]),
      .fn_en (fn_en),
      .r_bit (result[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_out  = chain[WIDTH] & fn_en[ALU_ADD];
  assign overflow_o = (chain[WIDTH] ^ chain[MSB]) & fn_en[ALU_ADD];

  always_comb begin
    if (!$isunknown({op_a, op_b, fn_sel, carry_in})) begin
      // R7: no unknown bit on the result
      p_known_result_r7: assert (!$isunknown(result));
      if (fn_sel == ALU_ADD) begin
        // R5: sign rule for two's-complement overflow
        p_sign_overflow_r5: assert (overflow_o ==
          ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])));
      end else begin
        // R6: flags stay low outside addition
        p_flags_quiet_r6: assert (!carry_out && !overflow_o);
      end
    end
  end

endmodule

// File: tb/bitslice_alu_tb_top.sv
`timescale 1ns/1ps
module bitslice_alu_tb_top;

  localparam int unsigned W4 = 4;
  localparam int unsigned W8 = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done   = 1'b0;

  logic [W4-1:0] a4, b4, r4;
  logic [1:0]    f4;
  logic          c4, co4, ov4;
  logic [W8-1:0] a8, b8, r8;
  logic [1:0]    f8;
  logic          c8, co8, ov8;

  bitslice_alu #(.WIDTH(W4)) dut_i (
    .op_a (a4), .op_b (b4), .fn_sel (f4), .carry_in (c4),
    .result (r4), .carry_out (co4), .overflow_o (ov4)
  );

  bitslice_alu #(.WIDTH(W8)) dut8_i (
    .op_a (a8), .op_b (b8), .fn_sel (f8), .carry_in (c8),
    .result (r8), .carry_out (co8), .overflow_o (ov8)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect4;
    logic [W4:0]   s;
    logic [W4-1:0] er;
    logic          eco, eov;
    s   = {1'b0, a4} + {1'b0, b4} + (W4+1)'(c4);
    eco = 1'b0;
    eov = 1'b0;
    case (f4)
      2'b00: begin
        er  = s[W4-1:0];
        eco = s[W4];
        eov = (a4[W4-1] == b4[W4-1]) && (s[W4-1] != a4[W4-1]);
      end
      2'b01:   er = ~a4;
      2'b10:   er = a4 | b4;
      default: er = a4 & b4;
    endcase
    case (f4)
      2'b00:   chk("R1 sum4", 32'(r4), 32'(er));
      2'b01:   chk("R2 inv4", 32'(r4), 32'(er));
      2'b10:   chk("R3 or4", 32'(r4), 32'(er));
      default: chk("R4 and4", 32'(r4), 32'(er));
    endcase
    if (f4 == 2'b00) begin
      chk("R1 carry4", 32'(co4), 32'(eco));
      chk("R5 ovf4", 32'(ov4), 32'(eov));
    end else begin
      chk("R6 flags4", 32'({co4, ov4}), 32'd0);
    end
    chk("R7 known4", 32'($isunknown(r4)), 32'd0);
  endtask

  task automatic run8(input logic [W8-1:0] a, input logic [W8-1:0] b,
                      input logic [1:0] f, input logic c);
    logic [W8:0]   s;
    logic [W8-1:0] er;
    @(posedge clk);
    a8 = a; b8 = b; f8 = f; c8 = c;
    @(negedge clk);
    s = {1'b0, a} + {1'b0, b} + (W8+1)'(c);
    case (f)
      2'b00:   er = s[W8-1:0];
      2'b01:   er = ~a;
      2'b10:   er = a | b;
      default: er = a & b;
    endcase
    chk("R8 result8", 32'(r8), 32'(er));
    if (f == 2'b00) begin
      chk("R1 carry8", 32'(co8), 32'(s[W8]));
      chk("R5 ovf8", 32'(ov8),
          32'((a[W8-1] == b[W8-1]) && (s[W8-1] != a[W8-1])));
    end else begin
      chk("R6 flags8", 32'({co8, ov8}), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a4 = '0; b4 = '0; f4 = 2'b00; c4 = 1'b0;
    a8 = '0; b8 = '0; f8 = 2'b00; c8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: zero operands add to zero with no flags (R1)
    chk("R1 idle", 32'({r4, co4, ov4}), 32'd0);

    // exhaustive 4-bit sweep covers R1..R7
    for (int f = 0; f < 4; f++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            @(posedge clk);
            a4 = W4'(a); b4 = W4'(b); f4 = 2'(f); c4 = 1'(c);
            @(negedge clk);
            expect4();
          end
        end
      end
    end

    // R6: carry_in leaves non-add results unchanged
    for (int f = 1; f < 4; f++) begin
      logic [W4-1:0] keep;
      @(posedge clk);
      a4 = 4'b1010; b4 = 4'b0110; f4 = 2'(f); c4 = 1'b0;
      @(negedge clk);
      keep = r4;
      @(posedge clk);
      c4 = 1'b1;
      @(negedge clk);
      chk("R6 cin ignored", 32'(r4), 32'(keep));
    end

    // R8 with R1/R5 corners on the 8-bit instance
    for (int c = 0; c < 2; c++) begin
      run8(8'hFF, 8'h01, 2'b00, 1'(c));
      run8(8'h7F, 8'h01, 2'b00, 1'(c));
      run8(8'h80, 8'h80, 2'b00, 1'(c));
    end
    for (int n = 0; n < 400; n++) begin
      run8(W8'($urandom), W8'($urandom), 2'(n % 4), 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule